// File: doc/BRIEF.md
# Sideband Doorbell Message Bridge

This block lets a host processor issue single-word transactions onto a narrow sideband fabric through a small set of registers. Software loads a target address and a data word. It then writes a packed doorbell word that names the destination port, the command opcode, the device/function number, a byte-enable mask and a BAR index. Setting the doorbell's busy bit launches one request toward the fabric. The bit reads back as 1 until the transaction completes.

The downstream side presents the request on a valid/ready channel and waits for a single-cycle response strobe. Two opcodes are reads, and the returned word lands in the data register. All other opcodes are writes that carry the data register as payload. If the target never answers within a programmable number of cycles, the bridge drops the transaction, clears busy and raises a sticky timeout flag. Software clears that flag by writing 1 to it. While a transaction is in flight, every field it uses is frozen against host writes.

Top module: `sbdb_bridge`

## Requirements
- R1: After reset the address, data, doorbell and status registers read 0, the timeout-limit register reads the TMO_RESET parameter value, and req_valid is 0.
- R2: host_addr selects the register: 0 address, 1 data, 2 doorbell, 3 status, 4 timeout limit. A write with host_we stores host_wdata at the rising edge. host_rdata is combinational from host_addr, and any other index reads 0.
- R3: Doorbell bit layout is busy at bit 0, BAR index at 3:1, byte enables at 7:4, opcode at 15:8, port at 23:16 and device/function at 31:24. A doorbell write with bit 0 set, made while idle, launches exactly one transaction, and bit 0 reads 1 from the next cycle until that transaction ends. A doorbell write with bit 0 clear stores the fields and launches nothing.
- R4: req_valid rises in the cycle after the launching write. It stays high with stable req_addr, req_opcode, req_port, req_devfn, req_be and req_bar until a rising edge sees req_ready. These outputs equal the address register and the doorbell fields.
- R5: Opcodes 0x00 and 0x06 are reads. For these, req_data is 0 whatever the data register holds, and rsp_data is stored in the data register when the response is taken.
- R6: Every other opcode is a write. For these, req_data equals the data register, and completion leaves the data register unchanged.
- R7: Once the request has been accepted, a rising edge with rsp_valid completes the transaction, and busy reads 0 in the next cycle. rsp_valid while idle, or before the request has been accepted, is ignored.
- R8: While busy, host writes to the address, data, doorbell and timeout-limit registers are ignored, and no second transaction is launched.
- R9: With timeout limit L and no response, busy reads 1 on exactly L+1 consecutive cycles after the launch edge, then clears, and status bit 0 becomes 1.
- R10: Status bit 0 is sticky. Writing 1 to bit 0 clears it, and writing 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data of the selected register |
| req_valid | output | 1 | Sideband request valid |
| req_ready | input | 1 | Sideband request accepted |
| req_port | output | 8 | Destination port |
| req_opcode | output | 8 | Command opcode |
| req_devfn | output | 8 | Device/function number |
| req_be | output | 4 | Byte-enable mask |
| req_bar | output | 3 | BAR index |
| req_addr | output | 32 | Target address |
| req_data | output | 32 | Write payload, 0 for reads |
| rsp_valid | input | 1 | Completion strobe from the target |
| rsp_data | input | 32 | Read data returned with the completion |

## Verification
The bench builds the bridge with TMO_W=6 and TMO_RESET=20. With these values, the full timeout window, up to the all-ones limit of 63, can be exercised in a few hundred cycles. The bench sweeps every timeout limit from 0 to 7 plus the limit 63, so the exact L+1 busy length is checked in both the request and the response phase. The transaction sweep crosses read and write opcodes with request-acceptance delays of 0 to 2 cycles and response delays of 0 to 2 cycles. Expected payloads, field values and returned words are derived arithmetically from the sweep indices.

// File: rtl/sbdb_pkg.sv
package sbdb_pkg;

  localparam int WORD_W = 32;
  localparam int HA_W   = 3;

  // host register indices
  localparam logic [HA_W-1:0] RA_ADDR = 3'd0;
  localparam logic [HA_W-1:0] RA_DATA = 3'd1;
  localparam logic [HA_W-1:0] RA_DOOR = 3'd2;
  localparam logic [HA_W-1:0] RA_STAT = 3'd3;
  localparam logic [HA_W-1:0] RA_TLIM = 3'd4;

  localparam int DB_BUSY = 0;

  // read opcodes; everything else is a write
  localparam logic [7:0] OPC_MMIO_RD = 8'h00;
  localparam logic [7:0] OPC_PRIV_RD = 8'h06;

  // doorbell bits 31:1, msb first
  typedef struct packed {
    logic [7:0] devfn;
    logic [7:0] port;
    logic [7:0] opc;
    logic [3:0] be;
    logic [2:0] bar;
  } db_fields_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } sb_state_e;

  function automatic logic op_is_read(input logic [7:0] opc);
    return (opc == OPC_MMIO_RD) || (opc == OPC_PRIV_RD);
  endfunction

endpackage

// File: rtl/sbdb_regs.sv
module sbdb_regs
  import sbdb_pkg::*;
#(
  parameter int          TMO_W     = 16,
  parameter int unsigned TMO_RESET = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [HA_W-1:0]   host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              busy,
  input  logic              rsp_take,
  input  logic [WORD_W-1:0] rsp_data,
  input  logic              tmo_fire,
  output logic [WORD_W-1:0] addr_q,
  output logic [WORD_W-1:0] data_q,
  output db_fields_t        db_q,
  output logic [TMO_W-1:0]  tlim_q,
  output logic              launch
);

  logic              wr_idle;
  logic              rd_op;
  logic              stat_clr;
  logic              tmo_q;
  logic              tmo_d;
  logic              addr_en, data_en, db_en, tlim_en;
  logic [WORD_W-1:0] data_d;

  assign wr_idle  = host_we && !busy;
  assign launch   = wr_idle && (host_addr == RA_DOOR) && host_wdata[DB_BUSY];
  assign rd_op    = op_is_read(db_q.opc);
  assign stat_clr = host_we && (host_addr == RA_STAT) && host_wdata[0];

  // next-state
  always_comb begin
    addr_en = wr_idle && (host_addr == RA_ADDR);
    db_en   = wr_idle && (host_addr == RA_DOOR);
    tlim_en = wr_idle && (host_addr == RA_TLIM);
    data_en = 1'b0;
    data_d  = data_q;
    if (rsp_take && rd_op) begin
      data_en = 1'b1;
      data_d  = rsp_data;
    end else if (wr_idle && (host_addr == RA_DATA)) begin
      data_en = 1'b1;
      data_d  = host_wdata;
    end
    tmo_d = tmo_q;
    if (stat_clr) tmo_d = 1'b0;
    if (tmo_fire) tmo_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      db_q   <= '0;
      tlim_q <= TMO_W'(TMO_RESET);
      tmo_q  <= 1'b0;
    end else begin
      if (addr_en) addr_q <= host_wdata;
      if (data_en) data_q <= data_d;
      if (db_en)   db_q   <= host_wdata[WORD_W-1:1];
      if (tlim_en) tlim_q <= host_wdata[TMO_W-1:0];
      tmo_q <= tmo_d;
    end
  end

  // read mux
  always_comb begin
    case (host_addr)
      RA_ADDR: host_rdata = addr_q;
      RA_DATA: host_rdata = data_q;
      RA_DOOR: host_rdata = {db_q, busy};
      RA_STAT: host_rdata = {{(WORD_W-1){1'b0}}, tmo_q};
      RA_TLIM: host_rdata = WORD_W'(tlim_q);
      default: host_rdata = '0;
    endcase
  end

  AST_RD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && rd_op) |=> (data_q == $past(rsp_data))); // R5
  AST_WR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && !rd_op) |=> $stable(data_q)); // R6
  AST_ADDR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(addr_q) && $stable(db_q) && $stable(tlim_q))); // R8
  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q && !stat_clr) |=> tmo_q); // R10

endmodule

// File: rtl/sbdb_tmo.sv
module sbdb_tmo #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             busy,
  input  logic             rsp_take,
  input  logic [TMO_W-1:0] limit,
  output logic             tmo_fire
);

  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W-1:0] cnt_d;
  logic             cnt_en;

  // a response at the limit edge wins over the timeout
  assign tmo_fire = busy && !rsp_take && (cnt_q == limit);

  always_comb begin
    cnt_en = launch || busy;
    cnt_d  = launch ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= limit)); // R9

endmodule

// File: rtl/sbdb_ctrl.sv
module sbdb_ctrl
  import sbdb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic req_ready,
  input  logic rsp_valid,
  input  logic tmo_fire,
  output logic busy,
  output logic req_valid,
  output logic rsp_take
);

  sb_state_e state_q;
  sb_state_e state_d;

  assign busy      = (state_q != ST_IDLE);
  assign req_valid = (state_q == ST_REQ);
  assign rsp_take  = (state_q == ST_WAIT) && rsp_valid;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (launch) state_d = ST_REQ;
      ST_REQ: begin
        if (tmo_fire)       state_d = ST_IDLE;
        else if (req_ready) state_d = ST_WAIT;
      end
      ST_WAIT: if (rsp_valid || tmo_fire) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !tmo_fire) |=> req_valid); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!req_valid && !rsp_take)); // R7
  AST_LAUNCH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> req_valid); // R3

endmodule

// File: rtl/sbdb_bridge.sv
module sbdb_bridge
  import sbdb_pkg::*;
#(
  parameter int          TMO_W     = 16,
  parameter int unsigned TMO_RESET = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [2:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [7:0]  req_port,
  output logic [7:0]  req_opcode,
  output logic [7:0]  req_devfn,
  output logic [3:0]  req_be,
  output logic [2:0]  req_bar,
  output logic [31:0] req_addr,
  output logic [31:0] req_data,
  input  logic        rsp_valid,
  input  logic [31:0] rsp_data
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              busy;
  logic              rsp_take;
  logic              tmo_fire;
  logic              launch;
  logic [WORD_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  db_fields_t        db_q;
  logic [TMO_W-1:0]  tlim_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  sbdb_regs #(.TMO_W(TMO_W), .TMO_RESET(TMO_RESET)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .busy       (busy),
    .rsp_take   (rsp_take),
    .rsp_data   (rsp_data),
    .tmo_fire   (tmo_fire),
    .addr_q     (addr_q),
    .data_q     (data_q),
    .db_q       (db_q),
    .tlim_q     (tlim_q),
    .launch     (launch)
  );

  sbdb_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .launch    (launch),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .tmo_fire  (tmo_fire),
    .busy      (busy),
    .req_valid (req_valid),
    .rsp_take  (rsp_take)
  );

  sbdb_tmo #(.TMO_W(TMO_W)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .launch   (launch),
    .busy     (busy),
    .rsp_take (rsp_take),
    .limit    (tlim_q),
    .tmo_fire (tmo_fire)
  );

  assign req_addr   = addr_q;
  assign req_port   = db_q.port;
  assign req_opcode = db_q.opc;
  assign req_devfn  = db_q.devfn;
  assign req_be     = db_q.be;
  assign req_bar    = db_q.bar;
  assign req_data   = op_is_read(db_q.opc) ? '0 : data_q;

  AST_TMO_ENDS: assert property (@(posedge clk) disable iff (!rst_n_s)
    tmo_fire |=> !busy); // R9
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && !req_ready && !tmo_fire) |=> ($stable(req_addr) && $stable(req_opcode) && $stable(req_port))); // R4

endmodule

// File: tb/sbdb_bridge_bench.sv
`timescale 1ns/1ps
module sbdb_bridge_bench;

  localparam int TW   = 6;
  localparam int TRST = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_we;
  logic [2:0]  host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        req_valid;
  logic        req_ready;
  logic [7:0]  req_port, req_opcode, req_devfn;
  logic [3:0]  req_be;
  logic [2:0]  req_bar;
  logic [31:0] req_addr, req_data;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sbdb_bridge #(.TMO_W(TW), .TMO_RESET(TRST)) u_sbdb_bridge (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_port(req_port), .req_opcode(req_opcode),
    .req_devfn(req_devfn), .req_be(req_be), .req_bar(req_bar),
    .req_addr(req_addr), .req_data(req_data), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  function automatic logic [31:0] pack(input logic [7:0] dv, input logic [7:0] pt,
                                       input logic [7:0] op, input logic [3:0] be,
                                       input logic [2:0] bar, input logic go);
    return {dv, pt, op, be, bar, go};
  endfunction

  function automatic bit is_rd(input logic [7:0] op);
    return (op == 8'h00) || (op == 8'h06);
  endfunction

  task automatic run_txn(input logic [7:0] op, input int rdly, input int sdly, input int idx);
    logic [31:0] a, wd, rv, db, r;
    logic [7:0]  pt, dv;
    logic [3:0]  be;
    logic [2:0]  bar;
    a   = 32'h1000_0000 + idx * 32'h0004_0104;
    wd  = 32'hA5A5_0000 ^ (idx * 32'h0101_0011);
    rv  = ~wd ^ idx;
    pt  = 8'h10 + 8'(idx);
    dv  = 8'h80 | 8'(idx);
    be  = 4'(idx);
    bar = 3'(idx);
    db  = pack(dv, pt, op, be, bar, 1'b0);
    hwrite(3'd0, a);
    hwrite(3'd1, wd);
    hwrite(3'd2, db | 32'h1);
    hread(3'd2, r);
    chk("R3 doorbell busy readback", r, db | 32'h1);
    chk("R4 req_valid after launch", {31'b0, req_valid}, 32'h1);
    for (int j = 0; j < rdly; j++) begin
      if (j == 0) begin rsp_valid = 1'b1; rsp_data = 32'hBAD0_0000; end
      @(negedge clk);
      rsp_valid = 1'b0;
      chk("R4 req_valid held", {31'b0, req_valid}, 32'h1);
      if (j == 0) begin
        hread(3'd2, r);
        chk("R7 early rsp ignored", {31'b0, r[0]}, 32'h1);
      end
    end
    chk("R4 req_addr", req_addr, a);
    chk("R4 req_port", {24'b0, req_port}, {24'b0, pt});
    chk("R4 req_opcode", {24'b0, req_opcode}, {24'b0, op});
    chk("R4 req_devfn", {24'b0, req_devfn}, {24'b0, dv});
    chk("R4 req_be/bar", {25'b0, req_be, req_bar}, {25'b0, be, bar});
    if (is_rd(op)) chk("R5 read payload zero", req_data, 32'h0);
    else           chk("R6 write payload", req_data, wd);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    for (int j = 0; j < sdly; j++) begin
      hread(3'd2, r);
      chk("R7 busy while waiting", {31'b0, r[0]}, 32'h1);
      @(negedge clk);
    end
    rsp_valid = 1'b1; rsp_data = rv;
    @(negedge clk);
    rsp_valid = 1'b0;
    hread(3'd2, r);
    chk("R7 busy cleared", r, db);
    chk("R7 req_valid low", {31'b0, req_valid}, 32'h0);
    hread(3'd1, r);
    if (is_rd(op)) chk("R5 read data stored", r, rv);
    else           chk("R6 data kept", r, wd);
  endtask

  initial begin
    logic [31:0] r;
    logic [7:0]  ops [7];
    int n;
    int lims [9];
    ops  = '{8'h00, 8'h01, 8'h06, 8'h07, 8'h02, 8'h05, 8'hFF};
    lims = '{0, 1, 2, 3, 4, 5, 6, 7, 63};
    rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    for (int k = 0; k < 4; k++) begin
      hread(3'(k), r);
      chk("R1 reset register zero", r, 32'h0);
    end
    hread(3'd4, r);
    chk("R1 reset timeout limit", r, TRST);
    chk("R1 reset req_valid", {31'b0, req_valid}, 32'h0);
    for (int k = 5; k < 8; k++) begin
      hread(3'(k), r);
      chk("R2 unmapped reads zero", r, 32'h0);
    end

    // register map and store-only doorbell
    hwrite(3'd0, 32'hCAFE_0123);
    hwrite(3'd1, 32'h0BAD_F00D);
    hwrite(3'd4, 32'd33);
    hread(3'd0, r); chk("R2 address readback", r, 32'hCAFE_0123);
    hread(3'd1, r); chk("R2 data readback", r, 32'h0BAD_F00D);
    hread(3'd4, r); chk("R2 limit readback", r, 32'd33);
    hwrite(3'd2, pack(8'h5A, 8'h21, 8'h07, 4'hF, 3'd0, 1'b0));
    repeat (2) begin
      chk("R3 no launch without busy bit", {31'b0, req_valid}, 32'h0);
      @(negedge clk);
    end
    hread(3'd2, r);
    chk("R3 stored fields", r, pack(8'h5A, 8'h21, 8'h07, 4'hF, 3'd0, 1'b0));

    // transaction sweep
    n = 0;
    foreach (ops[o])
      for (int rd = 0; rd < 3; rd++)
        for (int sd = 0; sd < 3; sd++) begin
          run_txn(ops[o], rd, sd, n);
          n++;
        end

    // stray response while idle
    hread(3'd1, r);
    rsp_valid = 1'b1; rsp_data = 32'hDEAD_BEEF;
    @(negedge clk);
    rsp_valid = 1'b0;
    begin
      logic [31:0] r2;
      hread(3'd1, r2);
      chk("R7 idle rsp ignored", r2, r);
    end

    // timeout sweep
    foreach (lims[i]) begin
      hwrite(3'd4, lims[i]);
      hwrite(3'd2, pack(8'h01, 8'h44, 8'h06, 4'hF, 3'd0, 1'b1));
      req_ready = i[0];
      n = 0;
      hread(3'd2, r);
      while (r[0] && n < 200) begin
        n++;
        @(negedge clk);
        req_ready = 1'b0;
        hread(3'd2, r);
      end
      req_ready = 1'b0;
      chk("R9 busy length L+1", n, lims[i] + 1);
      hread(3'd3, r); chk("R9 timeout flag set", r, 32'h1);
      hwrite(3'd3, 32'h0);
      hread(3'd3, r); chk("R10 write 0 keeps flag", r, 32'h1);
      hwrite(3'd3, 32'h1);
      hread(3'd3, r); chk("R10 write 1 clears flag", r, 32'h0);
    end

    // writes while busy are ignored
    hwrite(3'd4, 32'd30);
    hwrite(3'd0, 32'h1234_5678);
    hwrite(3'd1, 32'h8765_4321);
    hwrite(3'd2, pack(8'h77, 8'h66, 8'h07, 4'hF, 3'd0, 1'b1));
    hwrite(3'd0, 32'hFFFF_0000);
    hwrite(3'd1, 32'h0000_FFFF);
    hwrite(3'd2, pack(8'h11, 8'h22, 8'h01, 4'h3, 3'd5, 1'b1));
    hwrite(3'd4, 32'd5);
    chk("R8 req_addr frozen", req_addr, 32'h1234_5678);
    chk("R8 req_port frozen", {24'b0, req_port}, 32'h66);
    chk("R8 req_data frozen", req_data, 32'h8765_4321);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    rsp_valid = 1'b1; rsp_data = 32'h5555_AAAA;
    @(negedge clk);
    rsp_valid = 1'b0;
    hread(3'd0, r); chk("R8 address kept", r, 32'h1234_5678);
    hread(3'd1, r); chk("R8 data kept", r, 32'h8765_4321);
    hread(3'd2, r); chk("R8 doorbell kept", r, pack(8'h77, 8'h66, 8'h07, 4'hF, 3'd0, 1'b0));
    hread(3'd4, r); chk("R8 limit kept", r, 32'd30);
    repeat (2) begin
      @(negedge clk);
      chk("R8 no second launch", {31'b0, req_valid}, 32'h0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule